// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that lets a bus controller load and read back a small bank of 8-bit configuration registers, such as the enable bits of individual clock outputs. The serial clock and data lines are sampled by the on-chip clock. Each line passes through a two-stage synchroniser, and the slave finds start, stop and repeated-start conditions from the synchronised levels. The data output is open-drain and is modelled as a single drive-low enable.

Bit 7 of the command byte picks the kind of access. With bit 7 set, the access is indexed and moves a single byte: bits 6:0 select the register. With bit 7 clear, the access is a counted block that starts at register 0 and auto-increments. In a block access a byte-count byte comes ahead of the data in both directions. Reads, single or block, return data after a repeated start with the read address. Every register is also driven in parallel on a flat output bus for the surrounding logic. Reset restores the fixed defaults.

Top module: `smb_cfg_slave`

## Requirements
- R1: While reset is held and after it is released, SDA is not driven, and register i reads its default: 0x0F for register 0, and the value i for registers 1 to 7. Register i sits on bits 8i+7:8i of the parallel bus.
- R2: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read). After any other address it acknowledges nothing and drives nothing until the next start condition, after which it responds normally again.
- R3: Byte write: address 0xD2, then a command with bit 7 = 1 and index in bits 6:0, then one data byte. Every byte is acknowledged and the data lands in the indexed register.
- R4: Byte read: address 0xD2, command with bit 7 = 1 and an index, repeated start, then 0xD3. The slave returns the indexed register MSB first, and the master NACKs it.
- R5: Block write: address 0xD2, command 0x00, a byte count, then data. Every byte is acknowledged, and the data fills registers 0, 1, 2 and upward in order.
- R6: Block read: address 0xD2, command 0x00, repeated start, 0xD3. The slave sends the byte count 0x08, then registers 0 to 7 in order. The master acknowledges each byte except the last.
- R7: The master may end a block transfer with stop after any complete byte. Only the registers already transferred are written.
- R8: Writes to index 8 or above, by byte or block access, are acknowledged and leave every register unchanged. Reads from such indices return 0x00.
- R9: Asserting reset in the middle of a transfer returns every register to its default and releases SDA.
- R10: In the acknowledge bit after each byte the slave sends, SDA is released. Apart from the cycle after a start or stop, the slave changes its drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| cfg_out | output | NREG*8 | All registers in parallel, register i in bits 8i+7:8i |

## Verification
Some rules can be checked on every cycle from the engine's phase and the bank's write port, and the assertions cover these. SDA changes only while SCL is low. The slave never drives in the ignore phase or in the master's acknowledge slot. The bank changes only after a write strobe, and an out-of-range strobe leaves it alone. Reset releases SDA. Other behaviour shows only at the bus, through the bench's scenarios: which address is acknowledged, the byte-count value and ordering of block reads, early stops, out-of-range reads returning zero, and recovery after a foreign address. The bench's model holds the expected register bank, and the parallel output bus is compared against it on every clock.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        P_IDLE,
        P_RX,
        P_RXACK,
        P_TX,
        P_TXACK,
        P_TXGO,
        P_IGN
    } phase_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_CNT,
        K_DATA
    } kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic kind_e next_kind(kind_e k, logic blk);
        case (k)
            K_ADDR:  return K_CMD;
            K_CMD:   return blk ? K_CNT : K_DATA;
            default: return K_DATA;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon
    import smb_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [1:0] scl_q, sda_q;
    logic       scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 2'b11;
            sda_q <= 2'b11;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[0], scl_i};
            sda_q <= {sda_q[0], sda_i};
            scl_p <= scl_q[1];
            sda_p <= sda_q[1];
        end
    end

    always_comb begin
        ev.scl   = scl_q[1];
        ev.sda   = sda_q[1];
        ev.start = scl_q[1] & scl_p & sda_p & ~sda_q[1];
        ev.stop  = scl_q[1] & scl_p & ~sda_p & sda_q[1];
        ev.rise  = scl_q[1] & ~scl_p;
        ev.fall  = ~scl_q[1] & scl_p;
    end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int                  NREG     = 8,
    parameter int                  IW       = 7,
    parameter logic [NREG*8-1:0]   DEFAULTS = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [IW-1:0]      rd_idx,
    output logic [7:0]         rd_data,
    output logic [NREG*8-1:0]  regs_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_flat[i*8 +: 8] <= DEFAULTS[i*8 +: 8];
            else if (wr_en && (int'(wr_idx) == i))
                regs_flat[i*8 +: 8] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREG; i++)
            if (int'(rd_idx) == i) rd_data = regs_flat[i*8 +: 8];
    end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int                 NREG     = 8,
    parameter logic [6:0]         DEV_ADDR = 7'h69,
    parameter logic [NREG*8-1:0]  DEFAULTS = 64'h0706_0504_0302_010F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_out
);
    localparam int         IW       = 7;
    localparam logic [7:0] CNT_BYTE = 8'(NREG);

    line_ev_t     ev;
    phase_e       phase;
    kind_e        kind;
    logic [3:0]   bitcnt;
    logic [7:0]   shreg;
    logic         rw, blk, cnt_done, oe;
    logic [IW-1:0] ptr;
    logic [7:0]   rd_data, ld_byte;
    logic         ld_is_cnt;
    logic         wr_en;
    logic         byte_done;

    smb_line_mon u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smb_reg_bank #(.NREG(NREG), .IW(IW), .DEFAULTS(DEFAULTS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (ptr),
        .wr_data   (shreg),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .regs_flat (cfg_out)
    );

    assign byte_done = (phase == P_RX) && ev.fall && (bitcnt == 4'd8)
                       && !ev.start && !ev.stop;
    assign wr_en     = byte_done && (kind == K_DATA);
    assign ld_is_cnt = blk && !cnt_done;
    assign ld_byte   = ld_is_cnt ? CNT_BYTE : rd_data;
    assign sda_oe    = oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= P_IDLE;
            kind     <= K_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            blk      <= 1'b0;
            cnt_done <= 1'b0;
            ptr      <= '0;
            oe       <= 1'b0;
        end else if (ev.start) begin
            phase  <= P_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            oe     <= 1'b0;
        end else if (ev.stop) begin
            phase <= P_IDLE;
            oe    <= 1'b0;
        end else begin
            case (phase)
                P_RX: begin
                    if (ev.rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        phase <= P_RXACK;
                        oe    <= 1'b1;
                        case (kind)
                            K_ADDR: begin
                                if (shreg[7:1] != DEV_ADDR) begin
                                    phase <= P_IGN;
                                    oe    <= 1'b0;
                                end else begin
                                    rw       <= shreg[0];
                                    cnt_done <= 1'b0;
                                end
                            end
                            K_CMD: begin
                                blk <= ~shreg[7];
                                ptr <= shreg[7] ? shreg[6:0] : '0;
                            end
                            K_DATA:  ptr <= ptr + 7'd1;
                            default: ;
                        endcase
                    end
                end
                P_RXACK: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            phase <= P_TX;
                            shreg <= ld_byte;
                            oe    <= ~ld_byte[7];
                            if (ld_is_cnt) cnt_done <= 1'b1;
                            else           ptr      <= ptr + 7'd1;
                        end else begin
                            phase <= P_RX;
                            oe    <= 1'b0;
                            kind  <= next_kind(kind, blk);
                        end
                    end
                end
                P_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 4'd7) begin
                            phase <= P_TXACK;
                            oe    <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + 4'd1;
                            shreg  <= {shreg[6:0], 1'b0};
                            oe     <= ~shreg[6];
                        end
                    end
                end
                P_TXACK: begin
                    if (ev.rise) phase <= ev.sda ? P_IGN : P_TXGO;
                end
                P_TXGO: begin
                    if (ev.fall) begin
                        bitcnt <= '0;
                        phase  <= P_TX;
                        shreg  <= ld_byte;
                        oe     <= ~ld_byte[7];
                        if (ld_is_cnt) cnt_done <= 1'b1;
                        else           ptr      <= ptr + 7'd1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
    import smb_cfg_pkg::*;
#(
    parameter int                NREG     = 8,
    parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_out,
    input logic              scl_s,
    input logic              start_det,
    input logic              stop_det,
    input phase_e            phase,
    input logic              wr_en,
    input logic [6:0]        wr_idx
);
    // R1, R9: reset releases the line and restores defaults
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!sda_oe && cfg_out == DEFAULTS));

    // R2: nothing is driven while the bus is being ignored
    a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase == P_IGN) |-> !sda_oe);

    // R10: master acknowledge slot is left to the master
    a_r10_txack_released: assert property (@(posedge clk) disable iff (rst)
        (phase == P_TXACK) |-> !sda_oe);

    // R10: drive changes only while SCL is low, start/stop aside
    a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !scl_s);

    // R3, R5: the bank changes only after a write strobe
    a_r5_bank_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_out) |-> $past(wr_en));

    // R8: an out-of-range strobe leaves the bank untouched
    a_r8_oob_discard: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_idx) >= NREG) |=> $stable(cfg_out));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .cfg_out   (cfg_out),
    .scl_s     (ev.scl),
    .start_det (ev.start),
    .stop_det  (ev.stop),
    .phase     (phase),
    .wr_en     (wr_en),
    .wr_idx    (ptr)
);

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb;
    localparam int NREG = 8;
    localparam int Q    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] cfg_out;
    wire  sda_line = !(m_low || sda_oe);

    int checks = 0, errors = 0, mism = 0, cycles = 0;
    bit settled = 1'b1, quiet = 1'b0;
    logic [7:0] model [NREG];

    always #10 clk = ~clk;

    smb_cfg_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_out(cfg_out)
    );

    function automatic logic [7:0] def_val(int i);
        return (i == 0) ? 8'h0F : 8'(i);
    endfunction

    function automatic logic [NREG*8-1:0] model_vec();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    // behavioural model compared on every clock
    always @(negedge clk) begin
        cycles++;
        if (!rst && settled && cfg_out !== model_vec()) mism++;
        if (!rst && quiet && sda_oe) mism++;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_model(string req);
        check(mism == 0, req, "bus vs model mismatching clocks", mism, 0);
        mism = 0;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_low = 0; tick(Q); scl = 1; tick(Q); m_low = 1; tick(Q); scl = 0; tick(Q);
    endtask

    task automatic m_stop();
        m_low = 1; tick(Q); scl = 1; tick(Q); m_low = 0; tick(Q);
    endtask

    task automatic wr_bit(bit b);
        m_low = !b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    endtask

    task automatic rd_bit(output bit b);
        m_low = 0; tick(Q); scl = 1; tick(Q); b = sda_line; tick(Q); scl = 0; tick(Q);
    endtask

    task automatic wr_byte(logic [7:0] d, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) wr_bit(d[i]);
        rd_bit(a);
        ack = !a;
    endtask

    task automatic rd_byte(output logic [7:0] d, input bit ack, input string req);
        bit b;
        for (int i = 7; i >= 0; i--) begin rd_bit(b); d[i] = b; end
        m_low = ack; tick(Q); scl = 1; tick(Q);
        if (!ack) check(sda_line == 1'b1, req, "line during master NACK", sda_line, 1);
        tick(Q); scl = 0; tick(Q);
    endtask

    task automatic wr_data(logic [7:0] d, int idx, output bit ack);
        settled = 0;
        wr_byte(d, ack);
        if (idx < NREG) model[idx] = d;
        settled = 1;
    endtask

    task automatic byte_write(logic [6:0] idx, logic [7:0] d, string req);
        bit a0, a1, a2;
        m_start();
        wr_byte(8'hD2, a0);
        wr_byte({1'b1, idx}, a1);
        wr_data(d, int'(idx), a2);
        m_stop();
        check(a0 && a1 && a2, req, "byte write acks", {a0, a1, a2}, 3'b111);
    endtask

    task automatic byte_read(logic [6:0] idx, output logic [7:0] d, input string req);
        bit a0, a1, a2;
        m_start();
        wr_byte(8'hD2, a0);
        wr_byte({1'b1, idx}, a1);
        m_start();
        wr_byte(8'hD3, a2);
        rd_byte(d, 1'b0, "R10");
        m_stop();
        check(a0 && a1 && a2, req, "byte read acks", {a0, a1, a2}, 3'b111);
    endtask

    task automatic block_write(int count, int nsend, int base, string req);
        bit a, all;
        all = 1;
        m_start();
        wr_byte(8'hD2, a); all &= a;
        wr_byte(8'h00, a); all &= a;
        wr_byte(8'(count), a); all &= a;
        for (int i = 0; i < nsend; i++) begin
            wr_data(8'(base + 17 * i), i, a);
            all &= a;
        end
        m_stop();
        check(all, req, "block write acks", all, 1);
    endtask

    task automatic block_read(int nread, string req);
        bit a, all;
        logic [7:0] d;
        all = 1;
        m_start();
        wr_byte(8'hD2, a); all &= a;
        wr_byte(8'h00, a); all &= a;
        m_start();
        wr_byte(8'hD3, a); all &= a;
        check(all, req, "block read acks", all, 1);
        rd_byte(d, 1'b1, req);
        check(d == 8'h08, req, "byte count", d, 8'h08);
        for (int i = 0; i < nread; i++) begin
            rd_byte(d, i != nread - 1, req);
            check(d == model[i], req, $sformatf("block data %0d", i), d, model[i]);
        end
        m_stop();
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        bit a;
        for (int i = 0; i < NREG; i++) model[i] = def_val(i);
        tick(5);
        rst = 0;
        tick(5);
        // R1
        check(cfg_out == model_vec(), "R1", "defaults after reset", 0, 0);
        check(sda_oe == 1'b0, "R1", "line released after reset", sda_oe, 0);

        // R3 byte write, R4 byte read
        byte_write(7'd3, 8'hA5, "R3");
        chk_model("R3");
        byte_read(7'd3, d, "R4");
        check(d == 8'hA5, "R4", "read back idx 3", d, 8'hA5);
        byte_read(7'd0, d, "R4");
        check(d == 8'h0F, "R4", "read idx 0 default", d, 8'h0F);
        byte_write(7'd7, 8'h3C, "R3");
        byte_read(7'd7, d, "R4");
        check(d == 8'h3C, "R4", "read back idx 7", d, 8'h3C);
        check(sda_oe == 1'b0, "R10", "line released after stop", sda_oe, 0);

        // R2 foreign address ignored until next start
        quiet = 1;
        m_start();
        wr_byte(8'hA2, a);
        check(!a, "R2", "foreign address not acked", a, 0);
        wr_byte(8'h81, a);
        check(!a, "R2", "command after foreign address not acked", a, 0);
        wr_byte(8'h00, a);
        check(!a, "R2", "data after foreign address not acked", a, 0);
        m_stop();
        quiet = 0;
        chk_model("R2");
        byte_write(7'd1, 8'h5E, "R2");
        chk_model("R2");

        // R5 block write, R6 block read
        block_write(8, 8, 8'h40, "R5");
        chk_model("R5");
        block_read(8, "R6");

        // R7 early stops
        block_write(8, 3, 8'h90, "R7");
        chk_model("R7");
        check(model[3] == 8'h73 && cfg_out[31:24] == model[3], "R7",
              "reg 3 untouched by early stop", cfg_out[31:24], model[3]);
        block_read(2, "R7");
        byte_read(7'd2, d, "R7");
        check(d == model[2], "R7", "byte read after short block read", d, model[2]);

        // R8 out-of-range
        byte_write(7'h50, 8'h33, "R8");
        chk_model("R8");
        byte_read(7'h50, d, "R8");
        check(d == 8'h00, "R8", "out-of-range read", d, 8'h00);
        block_write(10, 10, 8'h11, "R8");
        chk_model("R8");

        // R9 reset mid-transfer
        m_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h80, a);
        settled = 0;
        for (int i = 0; i < 4; i++) wr_bit(1'b0);
        rst = 1;
        tick(4);
        m_low = 0; scl = 1;
        for (int i = 0; i < NREG; i++) model[i] = def_val(i);
        tick(2);
        rst = 0;
        tick(4);
        settled = 1;
        check(cfg_out == model_vec(), "R9", "defaults after mid-transfer reset", 0, 0);
        check(sda_oe == 1'b0, "R9", "line released after reset", sda_oe, 0);
        byte_read(7'd4, d, "R9");
        check(d == 8'h04, "R9", "default readable after reset", d, 8'h04);
        chk_model("R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule